// File: doc/BRIEF.md
# Infrared Run-Length Capture Encoder

This block sits behind an infrared demodulator and turns its single-bit output into a stream of run-length bytes. The input can be inverted, then passes a two-flop synchronizer and is sampled once per sample tick. A fixed divider makes one tick from every 64 core clock cycles. A glitch filter removes level changes that are too short. A run counter then measures how long each filtered level lasts, in ticks.

Each finished run is pushed as one or more bytes on a valid/data interface. Bit 7 of a byte is the level of the run, and bits 6:0 hold the run length minus one. When no edge has been seen for a programmable number of 128-tick blocks, the run in progress is flushed and a one-cycle packet-end strobe marks the end of the packet. Downstream logic, such as a FIFO or a protocol decoder, takes the bytes as they come.

The control state machine has three states. CAP_OFF is the disabled state. CAP_WAIT waits for a filtered edge and emits nothing. CAP_RUN counts the current run. It moves between them on four transitions:
- enable: CAP_OFF to CAP_WAIT, when both enables are set.
- first edge: CAP_WAIT to CAP_RUN, on a filtered level change.
- idle flush: CAP_RUN to CAP_WAIT, when the idle limit is reached.
- disable: any state to CAP_OFF, when either enable clears.

Top module: `ir_runlen_capture`

## Requirements
- R1: Capture is active only while `glb_en` and `rx_en` are both 1. While inactive, no byte or strobe is produced and all counters and the filtered level are cleared to 0. A run cut short by disabling is never emitted.
- R2: One sample tick occurs every 64 core clock cycles while active. A level held for k*64 cycles counts as exactly k ticks. Bytes are single-cycle pulses at least one tick apart.
- R3: Byte format: bit 7 is the run level after inversion (1 = pulse) and bits 6:0 are the run length in ticks minus one. A byte is pushed when the filtered level changes.
- R4: When `pol_inv` is 1, the raw input is inverted before synchronizing, sampling and filtering.
- R5: A run longer than 128 ticks is emitted as bytes of the same level, each with value 0x7F, followed by one remainder byte. A run of exactly 128 ticks gives a single 0x7F byte.
- R6: A new level is accepted only after it has been sampled on `noise_thr` consecutive ticks. A `noise_thr` of 0 acts as 1. A shorter excursion is ignored, and its ticks count toward the surrounding run.
- R7: When a run reaches (`idle_thr`+1)*128 ticks with no filtered edge, its last byte (always 0x7F) is pushed with `pkt_end` high in the same cycle. `pkt_end` is never high without `byte_valid`.
- R8: After an idle flush, and after enabling, nothing is emitted until the next filtered edge. That edge starts a new run without emitting a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| pol_inv | input | 1 | Invert raw input |
| ir_in | input | 1 | Raw demodulator output, asynchronous |
| noise_thr | input | 6 | Glitch filter length in ticks |
| idle_thr | input | 8 | Idle limit in 128-tick blocks minus one |
| byte_valid | output | 1 | Run byte valid for one cycle |
| byte_data | output | 8 | Level in bit 7, length minus one in bits 6:0 |
| pkt_end | output | 1 | Packet end, high with the final byte |

## Verification
Short mixed pulses and spaces are used to check exact tick counts and the level tags. Pulses of exactly 128 and of 200 ticks separate a correct split into full chunks and a remainder from off-by-one splitting. Excursions of two ticks and of three ticks with a filter length of three show the boundary between a merged run and an accepted edge. A pulse longer than the idle limit shows that the flush takes the next edge as a fresh start. Inverted-input runs, and toggling while either enable is low (including a run cut short by disabling), show that inversion and gating act where they should.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_WAIT = 2'd1,
        CAP_RUN  = 2'd2
    } cap_state_e;
endpackage

// File: rtl/ir_rl_sync.sv
module ir_rl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ir_rl_ticker.sv
module ir_rl_ticker #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/ir_rl_glitch.sv
module ir_rl_glitch #(
    parameter int NW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          smp,
    input  logic [NW-1:0] thr,
    output logic          filt
);
    logic [NW-1:0] cnt;
    logic [NW:0]   cnt_inc;
    logic [NW:0]   thr_eff;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign thr_eff = (thr == '0) ? (NW+1)'(1) : {1'b0, thr};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (!run) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (tick) begin
            if (smp == filt) begin
                cnt <= '0;
            end else if (cnt_inc >= thr_eff) begin
                filt <= smp;
                cnt  <= '0;
            end else begin
                cnt <= cnt_inc[NW-1:0];
            end
        end
    end
endmodule

// File: rtl/ir_runlen_capture.sv
module ir_runlen_capture
    import ir_rl_pkg::*;
#(
    parameter int TICK_DIV    = 64,
    parameter int LEN_W       = 7,
    parameter int NTHR_W      = 6,
    parameter int ITHR_W      = 8,
    parameter int IDLE_LOG2   = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              rx_en,
    input  logic              pol_inv,
    input  logic              ir_in,
    input  logic [NTHR_W-1:0] noise_thr,
    input  logic [ITHR_W-1:0] idle_thr,
    output logic              byte_valid,
    output logic [LEN_W:0]    byte_data,
    output logic              pkt_end
);
    localparam int IDLE_W = ITHR_W + IDLE_LOG2;
    localparam logic [LEN_W:0] RUN_FULL = (LEN_W+1)'(1 << LEN_W);
    localparam logic [LEN_W:0] RUN_ONE  = (LEN_W+1)'(1);
    localparam logic [LEN_W-1:0] LEN_SAT = {LEN_W{1'b1}};

    logic act, smp, tick, filt;
    logic lvl;
    logic [LEN_W:0]  run_cnt;
    logic [LEN_W:0]  run_m1;
    logic [IDLE_W-1:0] idle_cnt;
    logic [IDLE_W-1:0] idle_last;
    logic edge_seen, idle_hit;
    cap_state_e state, nxt;

    assign act       = glb_en && rx_en;
    assign run_m1    = run_cnt - RUN_ONE;
    assign idle_last = {idle_thr, {IDLE_LOG2{1'b1}}};
    assign edge_seen = (filt != lvl);
    assign idle_hit  = (idle_cnt == idle_last);

    ir_rl_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ir_in ^ pol_inv),
        .dout (smp)
    );

    ir_rl_ticker #(.DIV(TICK_DIV)) i_ticker (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (act),
        .tick (tick)
    );

    ir_rl_glitch #(.NW(NTHR_W)) i_glitch (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (act),
        .tick (tick),
        .smp  (smp),
        .thr  (noise_thr),
        .filt (filt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_OFF;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (!act) begin
            nxt = CAP_OFF;
        end else begin
            unique case (state)
                CAP_OFF:  nxt = CAP_WAIT;
                CAP_WAIT: if (tick && edge_seen) nxt = CAP_RUN;
                CAP_RUN:  if (tick && !edge_seen && idle_hit) nxt = CAP_WAIT;
                default:  nxt = CAP_OFF;
            endcase
        end
    end

    // counters and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl        <= 1'b0;
            run_cnt    <= '0;
            idle_cnt   <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            pkt_end    <= 1'b0;
        end else if (!act) begin
            lvl        <= 1'b0;
            run_cnt    <= '0;
            idle_cnt   <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            pkt_end    <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            pkt_end    <= 1'b0;
            if (tick) begin
                unique case (state)
                    CAP_WAIT: begin
                        if (edge_seen) begin
                            lvl      <= filt;
                            run_cnt  <= RUN_ONE;
                            idle_cnt <= IDLE_W'(1);
                        end
                    end
                    CAP_RUN: begin
                        if (edge_seen) begin
                            byte_valid <= 1'b1;
                            byte_data  <= {lvl, run_m1[LEN_W-1:0]};
                            lvl        <= filt;
                            run_cnt    <= RUN_ONE;
                            idle_cnt   <= IDLE_W'(1);
                        end else if (idle_hit) begin
                            byte_valid <= 1'b1;
                            pkt_end    <= 1'b1;
                            byte_data  <= {lvl, run_cnt[LEN_W-1:0]};
                            run_cnt    <= '0;
                            idle_cnt   <= '0;
                        end else if (run_cnt == RUN_FULL) begin
                            byte_valid <= 1'b1;
                            byte_data  <= {lvl, LEN_SAT};
                            run_cnt    <= RUN_ONE;
                            idle_cnt   <= idle_cnt + 1'b1;
                        end else begin
                            run_cnt    <= run_cnt + 1'b1;
                            idle_cnt   <= idle_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ir_runlen_checker.sv
module ir_runlen_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       glb_en,
    input logic       rx_en,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       pkt_end
);
    // R1: nothing is pushed in the cycle after capture was off
    p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(glb_en && rx_en) |=> !byte_valid);

    // R2: bytes are single-cycle pulses
    p_byte_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R7: packet end only travels with a byte
    p_end_with_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> byte_valid);

    // R7: the flushed idle byte is a full chunk
    p_end_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> (byte_data[6:0] == 7'h7F));

    // R7: strobe lasts one cycle
    p_end_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end);
endmodule

bind ir_runlen_capture ir_runlen_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .rx_en     (rx_en),
    .byte_valid(byte_valid),
    .byte_data (byte_data),
    .pkt_end   (pkt_end)
);

// File: tb/test_ir_runlen_capture.sv
module test_ir_runlen_capture;
    localparam int TICK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glb_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       pol_inv = 1'b0;
    logic       ir_in = 1'b0;
    logic [5:0] noise_thr = 6'd1;
    logic [7:0] idle_thr = 8'd0;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       pkt_end;

    int total = 0;
    int bad = 0;

    logic [8:0] q_exp[$];
    string      q_req[$];

    always #2.5 clk = ~clk;

    ir_runlen_capture i_ir_runlen_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .glb_en    (glb_en),
        .rx_en     (rx_en),
        .pol_inv   (pol_inv),
        .ir_in     (ir_in),
        .noise_thr (noise_thr),
        .idle_thr  (idle_thr),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .pkt_end   (pkt_end)
    );

    task automatic chk(input bit ok, input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            if (q_exp.size() == 0) begin
                chk(1'b0, "R1/R8", "unexpected byte", {23'd0, pkt_end, byte_data}, 32'h0);
            end else begin
                logic [8:0] e;
                string r;
                e = q_exp.pop_front();
                r = q_req.pop_front();
                chk({pkt_end, byte_data} == e, r, "byte",
                    {23'd0, pkt_end, byte_data}, {23'd0, e});
            end
        end
    end

    task automatic push(input bit pe, input bit lv, input int len_m1, input string r);
        q_exp.push_back({pe, lv, 7'(len_m1)});
        q_req.push_back(r);
    endtask

    task automatic push_run(input bit lv, input int n, input string r);
        int left = n;
        while (left > 128) begin
            push(1'b0, lv, 127, r);
            left -= 128;
        end
        push(1'b0, lv, left - 1, r);
    endtask

    task automatic push_idle(input bit lv, input string r);
        for (int k = 0; k <= int'(idle_thr); k++)
            push(k == int'(idle_thr), lv, 127, r);
    endtask

    // drive a post-inversion level for a number of ticks
    task automatic hold(input bit lv, input int ticks);
        ir_in = lv ^ pol_inv;
        repeat (ticks * TICK) @(negedge clk);
    endtask

    task automatic drained(input string r);
        chk(q_exp.size() == 0, r, "items left in scoreboard", 32'(q_exp.size()), 32'h0);
    endtask

    task automatic tail();
        hold(1'b0, (int'(idle_thr) + 1) * 128 + 8);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!byte_valid && !pkt_end && byte_data == 8'h00, "R1", "reset outputs",
            {22'd0, byte_valid, pkt_end, byte_data}, 32'h0);

        // R1: one enable alone does nothing
        glb_en = 1'b1; rx_en = 1'b0;
        hold(1'b1, 5); hold(1'b0, 5); hold(1'b1, 5); hold(1'b0, 5);
        glb_en = 1'b0; rx_en = 1'b1;
        hold(1'b1, 5); hold(1'b0, 5);
        drained("R1");

        // R2 R3 R6 (noise 0 acts as 1) R7: basic mixed pattern
        noise_thr = 6'd0; idle_thr = 8'd0;
        glb_en = 1'b1;
        hold(1'b0, 4);
        push_run(1'b1, 10, "R3"); push_run(1'b0, 20, "R2");
        push_run(1'b1, 5, "R6"); push_idle(1'b0, "R7");
        hold(1'b1, 10); hold(1'b0, 20); hold(1'b1, 5); tail();
        drained("R3");

        // R5: exact 128 and long 200 runs, two-block idle
        noise_thr = 6'd1; idle_thr = 8'd1;
        hold(1'b0, 4);
        push_run(1'b1, 128, "R5"); push_run(1'b0, 3, "R3");
        push_run(1'b1, 200, "R5"); push_idle(1'b0, "R7");
        hold(1'b1, 128); hold(1'b0, 3); hold(1'b1, 200); tail();
        drained("R5");

        // R6: glitch of 2 ticks merges, 3 ticks accepted
        noise_thr = 6'd3; idle_thr = 8'd0;
        hold(1'b0, 4);
        push_run(1'b1, 37, "R6"); push_run(1'b0, 3, "R6");
        push_run(1'b1, 4, "R6"); push_idle(1'b0, "R7");
        hold(1'b1, 20); hold(1'b0, 2); hold(1'b1, 15);
        hold(1'b0, 3); hold(1'b1, 4); tail();
        drained("R6");

        // R8: pulse longer than idle limit, leftover ticks emit nothing
        noise_thr = 6'd1;
        hold(1'b0, 4);
        push_idle(1'b1, "R8");
        hold(1'b1, 178);
        drained("R8");
        push_idle(1'b0, "R8");
        tail();
        drained("R8");

        // R4: inverted input
        glb_en = 1'b0;
        pol_inv = 1'b1;
        hold(1'b0, 2);
        glb_en = 1'b1;
        hold(1'b0, 4);
        push_run(1'b1, 10, "R4"); push_run(1'b0, 20, "R4");
        push_run(1'b1, 5, "R4"); push_idle(1'b0, "R4");
        hold(1'b1, 10); hold(1'b0, 20); hold(1'b1, 5); tail();
        drained("R4");

        // R1: run cut short by disabling is dropped, restart is fresh
        pol_inv = 1'b0;
        hold(1'b0, 4);
        hold(1'b1, 30);
        rx_en = 1'b0;
        hold(1'b1, 10); hold(1'b0, 4);
        rx_en = 1'b1;
        hold(1'b0, 4);
        drained("R1");
        push_run(1'b1, 7, "R1"); push_idle(1'b0, "R1");
        hold(1'b1, 7); tail();
        drained("R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule